// File: doc/BRIEF.md
# Cached DRAM Cycle Decoder

This block is the control decoder of a DRAM that fronts its array with a single-row SRAM cache. Its inputs are the active-low strobes, already sampled into the core clock domain. A falling edge of row enable (`re_n`) is found by comparing the current sample with the previous one. At that edge the block reads the refresh strobe, the write/read select, the chip select and the column strobe, and picks one of these outcomes:

- an internal refresh;
- a DRAM write;
- a DRAM read, or a cache hit that skips the array;
- entry into self-refresh;
- nothing.

The block keeps several pieces of state. It holds the internal refresh counter and a register with the row that was last loaded into the cache. It latches the row address. It passes the column address and the read data through latches that are controlled by the column strobe.

Outputs are one-cycle pulses. Each pulse appears in the clock cycle after the edge at which the strobe change was sampled. The only level output is the self-refresh flag.

A write cycle in which the column strobe never falls counts as a refresh of the externally supplied row. It leaves the cached-row register untouched. While self-refresh is active, the block advances the refresh counter from its own interval timer.

No data moves through the block under flow control, so every pin is a plain control or status signal. There is no valid/ready pair and no back-pressure.

Top module: `cdram_cycle_ctrl`

## Requirements
- R1: After reset all pulse outputs and `self_refresh_active` are 0 and `refresh_count` is 0. The cached-row register is invalid, so the first read after reset is a miss.
- R2: When `rfsh_n` is 0 at a falling `re_n`, `refresh_start` pulses for one cycle and `refresh_row` shows the counter value. `refresh_count` increases by one in the cycle after `re_n` rises again.
- R3: When `rfsh_n` is 1 and `cs_n` is 0 at a falling `re_n`, `wr_sel`=1 opens a write cycle and `wr_sel`=0 opens a read cycle. In both cases `row_addr` captures `addr`. Every pulse appears exactly one cycle after the sampled edge, and at most one pulse is high at a time.
- R4: `col_addr` follows `addr[8:0]` while `cal_n` is 1 and holds the last value seen while it was high. `dq_out` follows `dq_in` while `cal_n` is 0 and holds while `cal_n` is 1.
- R5: `write_start` pulses only when `cal_n` falls with `we_n` at 0 inside an open write cycle. A falling `cal_n` outside a write cycle, or with `we_n` at 1, gives no pulse.
- R6: A read whose row equals a valid cached-row register pulses `cache_hit` instead of `read_start`, and no DRAM access or refresh takes place. A miss pulses `read_start` and loads the cached-row register with the new row.
- R7: A write cycle that ends (`re_n` rises) without any falling `cal_n` pulses `ext_refresh`, with `refresh_row` equal to the latched row. The cached-row register keeps its value.
- R8: A falling `re_n` while `cs_n`, `wr_sel`, `rfsh_n` and `we_n` are 1 and `cal_n` is 0 sets `self_refresh_active` and raises no pulse. The flag stays set until `re_n` is sampled high.
- R9: A falling `re_n` with `cs_n`=1 and `rfsh_n`=1 that does not match the R8 pattern is ignored. No pulse is raised, and `row_addr` and the cached-row register are unchanged.
- R10: An internal refresh (R2) is carried out even when `cs_n` is 1.
- R11: While in self-refresh, `refresh_count` increases by one every `SR_INTERVAL` cycles (default 16). The first step happens `SR_INTERVAL` cycles after the cycle in which the flag is first set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| re_n | input | 1 | Row enable, active low (sampled) |
| cal_n | input | 1 | Column address strobe, active low |
| we_n | input | 1 | Write enable, active low |
| wr_sel | input | 1 | 1 selects write, 0 selects read |
| rfsh_n | input | 1 | Internal refresh request, active low |
| cs_n | input | 1 | Chip select, active low |
| addr | input | 11 | Multiplexed row/column address |
| dq_in | input | 36 | Read data from the cache row |
| read_start | output | 1 | Pulse: DRAM read begins (cache miss) |
| write_start | output | 1 | Pulse: column write begins |
| refresh_start | output | 1 | Pulse: internal refresh begins |
| ext_refresh | output | 1 | Pulse: write cycle without column strobe refreshed `row_addr` |
| cache_hit | output | 1 | Pulse: read matched the cached row |
| self_refresh_active | output | 1 | Level: self-refresh in progress |
| row_addr | output | 11 | Latched row address |
| col_addr | output | 9 | Column latch output |
| refresh_row | output | 11 | Row of the most recent refresh |
| refresh_count | output | 11 | Internal refresh counter |
| dq_out | output | 36 | Output data latch |

## Verification
The hardest state to reach from the ports is the one where a refresh-only write cycle has run between two reads of the same row. The R7 scenario reaches it in three steps. It first reads a row to load the cached-row register. It then opens and closes a write cycle to a different row while never lowering `cal_n`. Finally it reads the first row again. A `cache_hit` on that last read shows that the register survived the write. Self-refresh timing is the other hard case: the bench holds the entry pattern for 40 cycles, expects exactly two counter steps, and then checks the exit.

// File: rtl/cdc_pkg.sv
package cdc_pkg;
  typedef enum logic [2:0] {
    CYC_IDLE,
    CYC_READ,
    CYC_WRITE,
    CYC_RFSH,
    CYC_SELF
  } cyc_e;
endpackage

// File: rtl/cdc_addr_latch.sv
module cdc_addr_latch #(
  parameter int COL_W = 9,
  parameter int DQ_W  = 36
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cal_n,
  input  logic [COL_W-1:0] col_in,
  input  logic [DQ_W-1:0]  dq_in,
  output logic [COL_W-1:0] col_out,
  output logic [DQ_W-1:0]  dq_out
);
  logic [COL_W-1:0] col_hold;
  logic [DQ_W-1:0]  dq_hold;

  // column side: open while strobe high, data side: open while strobe low
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_hold <= '0;
      dq_hold  <= '0;
    end else if (cal_n) begin
      col_hold <= col_in;
    end else begin
      dq_hold  <= dq_in;
    end
  end

  assign col_out = cal_n ? col_in : col_hold;
  assign dq_out  = cal_n ? dq_hold : dq_in;

  AST_COL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cal_n && $past(!cal_n)) |-> $stable(col_out)); // R4
endmodule

// File: rtl/cdc_refresh_ctr.sv
module cdc_refresh_ctr #(
  parameter int ROW_W       = 11,
  parameter int SR_INTERVAL = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             sr_run,
  output logic [ROW_W-1:0] count
);
  localparam int TW = (SR_INTERVAL > 2) ? $clog2(SR_INTERVAL) : 1;
  localparam logic [TW-1:0] TLAST = TW'(SR_INTERVAL - 1);

  logic [TW-1:0] timer;
  logic          tick;

  assign tick = sr_run && (timer == TLAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timer <= '0;
      count <= '0;
    end else begin
      if (!sr_run || tick) timer <= '0;
      else                 timer <= timer + 1'b1;
      if (step || tick)    count <= count + 1'b1;
    end
  end

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (count != $past(count)) |-> (count == ROW_W'($past(count) + 1'b1))); // R11
endmodule

// File: rtl/cdc_last_row.sv
module cdc_last_row #(
  parameter int ROW_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ROW_W-1:0] row_in,
  input  logic             load,
  output logic             hit
);
  logic [ROW_W-1:0] lrr;
  logic             lrr_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lrr    <= '0;
      lrr_ok <= 1'b0;
    end else if (load) begin
      lrr    <= row_in;
      lrr_ok <= 1'b1;
    end
  end

  assign hit = lrr_ok && (row_in == lrr);

  AST_LOAD_ONLY_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (lrr_ok && lrr == $past(row_in))); // R6
endmodule

// File: rtl/cdram_cycle_ctrl.sv
module cdram_cycle_ctrl
  import cdc_pkg::*;
#(
  parameter int ROW_W       = 11,
  parameter int COL_W       = 9,
  parameter int DQ_W        = 36,
  parameter int SR_INTERVAL = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             re_n,
  input  logic             cal_n,
  input  logic             we_n,
  input  logic             wr_sel,
  input  logic             rfsh_n,
  input  logic             cs_n,
  input  logic [ROW_W-1:0] addr,
  input  logic [DQ_W-1:0]  dq_in,
  output logic             read_start,
  output logic             write_start,
  output logic             refresh_start,
  output logic             ext_refresh,
  output logic             cache_hit,
  output logic             self_refresh_active,
  output logic [ROW_W-1:0] row_addr,
  output logic [COL_W-1:0] col_addr,
  output logic [ROW_W-1:0] refresh_row,
  output logic [ROW_W-1:0] refresh_count,
  output logic [DQ_W-1:0]  dq_out
);
  cyc_e cyc;
  logic re_q, cal_q, cal_seen;
  logic re_fall, re_rise, cal_fall;
  logic sr_pattern, row_hit, lrr_load, ctr_step, sr_run;

  assign re_fall    = re_q & ~re_n;
  assign re_rise    = ~re_q & re_n;
  assign cal_fall   = cal_q & ~cal_n;
  assign sr_pattern = cs_n & wr_sel & rfsh_n & we_n & ~cal_n;

  assign lrr_load = re_fall && (cyc == CYC_IDLE) && rfsh_n && !cs_n
                    && !wr_sel && !row_hit;
  assign ctr_step = re_rise && (cyc == CYC_RFSH);
  assign sr_run   = (cyc == CYC_SELF) && !re_n;
  assign self_refresh_active = (cyc == CYC_SELF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      re_q  <= 1'b1;
      cal_q <= 1'b1;
    end else begin
      re_q  <= re_n;
      cal_q <= cal_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc           <= CYC_IDLE;
      cal_seen      <= 1'b0;
      read_start    <= 1'b0;
      write_start   <= 1'b0;
      refresh_start <= 1'b0;
      ext_refresh   <= 1'b0;
      cache_hit     <= 1'b0;
      row_addr      <= '0;
      refresh_row   <= '0;
    end else begin
      read_start    <= 1'b0;
      write_start   <= 1'b0;
      refresh_start <= 1'b0;
      ext_refresh   <= 1'b0;
      cache_hit     <= 1'b0;
      if (re_fall && cyc == CYC_IDLE) begin
        if (!rfsh_n) begin
          cyc           <= CYC_RFSH;
          refresh_start <= 1'b1;
          refresh_row   <= refresh_count;
        end else if (sr_pattern) begin
          cyc <= CYC_SELF;
        end else if (!cs_n) begin
          row_addr <= addr;
          if (wr_sel) begin
            cyc      <= CYC_WRITE;
            cal_seen <= 1'b0;
          end else begin
            cyc <= CYC_READ;
            if (row_hit) cache_hit  <= 1'b1;
            else         read_start <= 1'b1;
          end
        end
      end else if (re_rise && cyc != CYC_IDLE) begin
        if (cyc == CYC_WRITE && !cal_seen) begin
          ext_refresh <= 1'b1;
          refresh_row <= row_addr;
        end
        cyc <= CYC_IDLE;
      end else if (cyc == CYC_WRITE && cal_fall) begin
        cal_seen <= 1'b1;
        if (!we_n) write_start <= 1'b1;
      end
    end
  end

  cdc_addr_latch #(.COL_W(COL_W), .DQ_W(DQ_W)) u_latch (
    .clk    (clk),
    .rst_n  (rst_n),
    .cal_n  (cal_n),
    .col_in (addr[COL_W-1:0]),
    .dq_in  (dq_in),
    .col_out(col_addr),
    .dq_out (dq_out)
  );

  cdc_refresh_ctr #(.ROW_W(ROW_W), .SR_INTERVAL(SR_INTERVAL)) u_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (ctr_step),
    .sr_run(sr_run),
    .count (refresh_count)
  );

  cdc_last_row #(.ROW_W(ROW_W)) u_lrr (
    .clk   (clk),
    .rst_n (rst_n),
    .row_in(addr),
    .load  (lrr_load),
    .hit   (row_hit)
  );

  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({read_start, write_start, refresh_start, ext_refresh, cache_hit})); // R3
  AST_WRITE_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
    write_start |-> $past(!cal_n && !we_n)); // R5
  AST_HIT_IS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    cache_hit |-> $past(!wr_sel && rfsh_n && !cs_n)); // R6
  AST_SELF_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (self_refresh_active && !re_n) |=> self_refresh_active); // R8
  AST_RFSH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_start |-> $past(!rfsh_n && !re_n)); // R2
endmodule

// File: tb/sim_cdram_cycle_ctrl.sv
`timescale 1ns/1ps
module sim_cdram_cycle_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        re_n = 1'b1, cal_n = 1'b1, we_n = 1'b1, wr_sel = 1'b0;
  logic        rfsh_n = 1'b1, cs_n = 1'b0;
  logic [10:0] addr = '0;
  logic [35:0] dq_in = '0;
  logic        read_start, write_start, refresh_start, ext_refresh, cache_hit;
  logic        self_refresh_active;
  logic [10:0] row_addr, refresh_row, refresh_count;
  logic [8:0]  col_addr;
  logic [35:0] dq_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cdram_cycle_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .re_n(re_n), .cal_n(cal_n), .we_n(we_n),
    .wr_sel(wr_sel), .rfsh_n(rfsh_n), .cs_n(cs_n), .addr(addr), .dq_in(dq_in),
    .read_start(read_start), .write_start(write_start),
    .refresh_start(refresh_start), .ext_refresh(ext_refresh),
    .cache_hit(cache_hit), .self_refresh_active(self_refresh_active),
    .row_addr(row_addr), .col_addr(col_addr), .refresh_row(refresh_row),
    .refresh_count(refresh_count), .dq_out(dq_out)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [4:0] pulses();
    return {read_start, write_start, refresh_start, ext_refresh, cache_hit};
  endfunction

  // falling row enable for a normal read or write
  task automatic open_cycle(input logic wr, input logic [10:0] row);
    wr_sel = wr; rfsh_n = 1'b1; addr = row; re_n = 1'b0;
    tick(1);
  endtask

  task automatic close_cycle();
    re_n = 1'b1;
    tick(1);
  endtask

  task automatic t_reset();
    chk("R1 pulses", pulses(), 5'b0);
    chk("R1 self", self_refresh_active, 1'b0);
    chk("R1 count", refresh_count, 11'd0);
  endtask

  task automatic t_read_hit();
    open_cycle(1'b0, 11'h155);
    chk("R1 first read misses", read_start, 1'b1);
    chk("R3 row latched", row_addr, 11'h155);
    chk("R6 no hit on miss", cache_hit, 1'b0);
    tick(1);
    chk("R3 pulse one cycle", pulses(), 5'b0);
    close_cycle();
    open_cycle(1'b0, 11'h155);
    chk("R6 hit pulse", pulses(), 5'b00001);
    close_cycle();
    open_cycle(1'b0, 11'h2AA);
    chk("R6 other row misses", pulses(), 5'b10000);
    close_cycle();
    open_cycle(1'b0, 11'h155);
    chk("R6 replaced row misses", pulses(), 5'b10000);
    close_cycle();
  endtask

  task automatic t_refresh();
    for (int i = 0; i < 2; i++) begin
      rfsh_n = 1'b0; re_n = 1'b0;
      tick(1);
      chk("R2 refresh pulse", pulses(), 5'b00100);
      chk("R2 refresh row", refresh_row, 11'(i));
      chk("R2 count held in cycle", refresh_count, 11'(i));
      re_n = 1'b1; rfsh_n = 1'b1;
      tick(1);
      chk("R2 count step", refresh_count, 11'(i + 1));
    end
  endtask

  task automatic t_write();
    cal_n = 1'b0; we_n = 1'b0;
    tick(1);
    chk("R5 no write outside cycle", write_start, 1'b0);
    cal_n = 1'b1; we_n = 1'b1;
    tick(1);
    open_cycle(1'b1, 11'h0A0);
    chk("R3 write open no pulse", pulses(), 5'b0);
    chk("R3 write row latched", row_addr, 11'h0A0);
    addr = 11'h033; cal_n = 1'b0; we_n = 1'b0;
    tick(1);
    chk("R5 write pulse", write_start, 1'b1);
    tick(1);
    chk("R5 write pulse ends", write_start, 1'b0);
    cal_n = 1'b1; we_n = 1'b1;
    tick(1);
    cal_n = 1'b0;
    tick(1);
    chk("R5 no write with we high", write_start, 1'b0);
    cal_n = 1'b1;
    close_cycle();
    chk("R7 no ext refresh after CAL", ext_refresh, 1'b0);
  endtask

  task automatic t_row_only_refresh();
    open_cycle(1'b0, 11'h2AA);
    chk("R6 load row", read_start, 1'b1);
    close_cycle();
    open_cycle(1'b1, 11'h111);
    tick(2);
    close_cycle();
    chk("R7 ext refresh pulse", pulses(), 5'b00010);
    chk("R7 ext refresh row", refresh_row, 11'h111);
    tick(1);
    chk("R7 pulse ends", ext_refresh, 1'b0);
    open_cycle(1'b0, 11'h2AA);
    chk("R7 cached row kept", pulses(), 5'b00001);
    close_cycle();
  endtask

  task automatic t_latches();
    addr = 11'h1A5; cal_n = 1'b1;
    tick(1);
    chk("R4 column transparent", col_addr, 9'h1A5);
    cal_n = 1'b0;
    tick(1);
    addr = 11'h0F0; dq_in = 36'h9_1234_5678;
    tick(1);
    chk("R4 column held", col_addr, 9'h1A5);
    chk("R4 data transparent", dq_out, 36'h9_1234_5678);
    dq_in = 36'hA_CAFE_F00D;
    tick(1);
    cal_n = 1'b1;
    tick(1);
    dq_in = 36'h3_0000_0001;
    tick(1);
    chk("R4 data held", dq_out, 36'hA_CAFE_F00D);
    chk("R4 column reopens", col_addr, 9'h0F0);
  endtask

  task automatic t_deselect();
    logic [10:0] prev;
    prev = row_addr;
    cs_n = 1'b1;
    open_cycle(1'b0, 11'h3C3);
    chk("R9 ignored no pulse", pulses(), 5'b0);
    chk("R9 row unchanged", row_addr, prev);
    close_cycle();
    rfsh_n = 1'b0; re_n = 1'b0;
    tick(1);
    chk("R10 refresh while deselected", refresh_start, 1'b1);
    re_n = 1'b1; rfsh_n = 1'b1;
    tick(1);
    cs_n = 1'b0;
    open_cycle(1'b0, 11'h3C3);
    chk("R9 cached row not loaded", pulses(), 5'b10000);
    close_cycle();
  endtask

  task automatic t_self_refresh();
    logic [10:0] c0;
    c0 = refresh_count;
    cs_n = 1'b1; wr_sel = 1'b1; rfsh_n = 1'b1; we_n = 1'b1; cal_n = 1'b0;
    re_n = 1'b0;
    tick(1);
    chk("R8 self refresh set", self_refresh_active, 1'b1);
    chk("R8 no pulse", pulses(), 5'b0);
    tick(39);
    chk("R11 two timed steps", refresh_count, c0 + 11'd2);
    chk("R8 still active", self_refresh_active, 1'b1);
    re_n = 1'b1;
    tick(1);
    chk("R8 exit on rise", self_refresh_active, 1'b0);
    chk("R11 no step on exit", refresh_count, c0 + 11'd2);
    cal_n = 1'b1; cs_n = 1'b0; wr_sel = 1'b0;
    tick(1);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_read_hit();
    t_refresh();
    t_write();
    t_row_only_refresh();
    t_latches();
    t_deselect();
    t_self_refresh();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule